// File: doc/BRIEF.md
# Cache ECC Error Reporting Unit

This block collects error-correction events raised by the tag (directory) and data arrays of a shared cache. It sorts them into four classes: directory corrected, data corrected, data uncorrectable and directory uncorrectable. For each class it keeps the address of the latest event, a saturating event count and a level interrupt. The ECC encoders, decoders and arrays lie outside the block. Each of them reports an event as a one-cycle strobe together with the failing address.

Software reaches the block through a simple 32-bit register port. Reads take one extra cycle. A read of a class's count register is the acknowledge that drops that class's interrupt. The same port exposes the following:
- a read-only geometry word;
- a way-enable byte that software can write;
- an error-injection register. It forwards only legal request values to the array logic, as a one-cycle pulse.

Each class tracker is a two-state machine. QUIET moves to PENDING on an event. PENDING moves back to QUIET on a count read that arrives without a new event. PENDING holds in every other case. The register port is also a two-state machine. IDLE moves to RESP when a read is accepted. RESP always returns to IDLE after one cycle. Writes are accepted in IDLE and leave the port in IDLE.

Top module: `ecc_report_unit`

## Requirements
- R1: After reset the following hold: all four interrupts are low, every address and count register reads 0, `reg_ready` is 1, and `reg_rvalid` and `inj_valid` are 0.
- R2: An event on a class stores its address. Bits 31:0 read at the class base, and bits 63:32 read at base+0x4. The bases are 0x100 for directory corrected, 0x120 for directory uncorrectable, 0x140 for data corrected and 0x160 for data uncorrectable. A later event overwrites the stored address.
- R3: The count register at base+0x8 grows by one per event of its class. It stops at 2^CNT_W-1. A read does not change it.
- R4: The interrupt of a class is high from the cycle after its event. The bits of `irq` are ordered as follows: bit 0 directory corrected, bit 1 data corrected, bit 2 data uncorrectable, bit 3 directory uncorrectable.
- R5: An accepted read of a class's count register lowers that class's interrupt in the following cycle. Reads of its address registers leave the interrupt unchanged.
- R6: If an event arrives in the same cycle as a count read of the same class, the interrupt stays high. The read returns the count as it was before that event.
- R7: A write to offset 0x40 is accepted when the value is below 0xFF, or lies from 0x10000 to 0x100FE. An accepted write gives `inj_valid` high for exactly the next cycle. In that cycle `inj_target` carries bit 16 of the value and `inj_bit` carries bits 7:0.
- R8: A write to 0x40 with any other value produces no `inj_valid` pulse.
- R9: Offset 0x00 reads as follows: BANKS in bits 7:0, WAYS in bits 15:8, LG_SETS in bits 23:16 and LG_BLOCK in bits 31:24.
- R10: Offset 0x08 returns the way-enable byte in bits 7:0, with zeros above it. The byte resets to WAYS-1. A write to 0x08 stores bits 7:0 of the write data.
- R11: A read is accepted when `reg_rd` is high and `reg_ready` is 1. `reg_rvalid` is then high with `reg_rdata` for the next cycle only. `reg_ready` is 0 during that cycle.
- R12: A read of any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 4 | One-cycle event per class, indexed as the `irq` bits |
| ev_addr | input | 4*ADDR_W | Failing address per class, class k in slice k |
| reg_rd | input | 1 | Read request |
| reg_wr | input | 1 | Write request (ignored when `reg_rd` is also high) |
| reg_addr | input | 12 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Port can accept a request |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| irq | output | 4 | Level interrupts per class |
| inj_valid | output | 1 | Injection request pulse |
| inj_target | output | 1 | Injection target select |
| inj_bit | output | 8 | Bit index to corrupt |

## Verification
The collision that matters is a new event landing on a class in the same cycle as the count read that acknowledges it. If the read wins, an event is lost without an interrupt. The bench drives the strobe and the count read in one cycle, both as a directed case and at random during a long mixed run. It then expects the interrupt to stay high and the returned count to be the value from before the event. The same model-based comparison covers collisions with saturation and with events on the other classes.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

    localparam int NUM_CLASSES = 4;
    localparam int REG_AW      = 12;

    localparam logic [REG_AW-1:0] OFS_GEOMETRY = 12'h000;
    localparam logic [REG_AW-1:0] OFS_WAY_EN   = 12'h008;
    localparam logic [REG_AW-1:0] OFS_INJECT   = 12'h040;

    typedef enum logic {
        CLS_QUIET,
        CLS_PENDING
    } cls_state_e;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_e;

    // Interrupt index -> register base. The index order is fixed by the
    // interrupt wiring, the base order by the register layout.
    function automatic logic [REG_AW-1:0] class_base(input int k);
        logic [REG_AW-1:0] b;
        case (k)
            0:       b = 12'h100;
            1:       b = 12'h140;
            2:       b = 12'h160;
            default: b = 12'h120;
        endcase
        return b;
    endfunction

    function automatic logic inject_ok(input logic [31:0] v);
        return (v < 32'h0000_00FF) ||
               ((v >= 32'h0001_0000) && (v < 32'h0001_00FF));
    endfunction

endpackage

// File: rtl/ecc_class_rec.sv
module ecc_class_rec
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              rd_clr,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cls_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CLS_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CLS_QUIET:   if (ev) state_nx = CLS_PENDING;
            CLS_PENDING: if (rd_clr && !ev) state_nx = CLS_QUIET;
        endcase
    end

    assign irq = (state == CLS_PENDING);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            count    <= '0;
        end else if (ev) begin
            cap_addr <= ev_addr;
            if (count != CNT_MAX) count <= count + 1'b1;
        end
    end

    assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (cap_addr == $past(ev_addr)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && (count != CNT_MAX)) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_count_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> irq);

    assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev) |=> !irq);

    assert_irq_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev) |=> irq);

endmodule

// File: rtl/ecc_inject_gate.sv
module ecc_inject_gate
    import ecc_rpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic        inj_valid,
    output logic        inj_target,
    output logic [7:0]  inj_bit
);

    logic take;
    assign take = wr_en && inject_ok(wdata);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_valid  <= 1'b0;
            inj_target <= 1'b0;
            inj_bit    <= '0;
        end else begin
            inj_valid <= take;
            if (take) begin
                inj_target <= wdata[16];
                inj_bit    <= wdata[7:0];
            end
        end
    end

    assert_inject_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (inj_valid && (inj_bit == $past(wdata[7:0]))
                  && (inj_target == $past(wdata[16]))));

    assert_inject_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inject_ok(wdata)) |=> !inj_valid);

endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CNT_W    = 32,
    parameter int BANKS    = 4,
    parameter int WAYS     = 16,
    parameter int LG_SETS  = 10,
    parameter int LG_BLOCK = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_rd,
    input  logic                                reg_wr,
    input  logic [REG_AW-1:0]                   reg_addr,
    input  logic [31:0]                         reg_wdata,
    input  logic [NUM_CLASSES-1:0][ADDR_W-1:0]  cls_addr,
    input  logic [NUM_CLASSES-1:0][CNT_W-1:0]   cls_count,
    output logic                                reg_ready,
    output logic                                reg_rvalid,
    output logic [31:0]                         reg_rdata,
    output logic [NUM_CLASSES-1:0]              rd_clr,
    output logic                                inj_wr
);

    localparam logic [31:0] GEOMETRY = {8'(LG_BLOCK), 8'(LG_SETS), 8'(WAYS), 8'(BANKS)};
    localparam logic [7:0]  WAY_RST  = 8'(WAYS - 1);

    port_state_e state, state_nx;
    logic        take_rd, take_wr;
    logic [7:0]  way_en;
    logic [31:0] rd_mux;

    assign take_rd = reg_rd && (state == PORT_IDLE);
    assign take_wr = reg_wr && !reg_rd && (state == PORT_IDLE);
    assign inj_wr  = take_wr && (reg_addr == OFS_INJECT);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PORT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PORT_IDLE: if (take_rd) state_nx = PORT_RESP;
            PORT_RESP: state_nx = PORT_IDLE;
        endcase
    end

    always_comb begin
        reg_ready  = (state == PORT_IDLE);
        reg_rvalid = (state == PORT_RESP);
    end

    always_comb begin
        logic [63:0] a64;
        rd_mux = '0;
        rd_clr = '0;
        if (reg_addr == OFS_GEOMETRY) rd_mux = GEOMETRY;
        if (reg_addr == OFS_WAY_EN)   rd_mux = {24'd0, way_en};
        for (int k = 0; k < NUM_CLASSES; k++) begin
            a64 = 64'(cls_addr[k]);
            if (reg_addr == class_base(k))          rd_mux = a64[31:0];
            if (reg_addr == class_base(k) + 12'h4)  rd_mux = a64[63:32];
            if (reg_addr == class_base(k) + 12'h8) begin
                rd_mux    = 32'(cls_count[k]);
                rd_clr[k] = take_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            way_en    <= WAY_RST;
        end else begin
            if (take_rd) reg_rdata <= rd_mux;
            if (take_wr && (reg_addr == OFS_WAY_EN)) way_en <= reg_wdata[7:0];
        end
    end

    assert_resp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |=> !reg_rvalid);

    assert_read_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_ready) |=> (reg_rvalid && !reg_ready));

    assert_clear_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_clr));

endmodule

// File: rtl/ecc_report_unit.sv
module ecc_report_unit
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CNT_W    = 32,
    parameter int BANKS    = 4,
    parameter int WAYS     = 16,
    parameter int LG_SETS  = 10,
    parameter int LG_BLOCK = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [3:0]                    ev_strobe,
    input  logic [4*ADDR_W-1:0]           ev_addr,
    input  logic                          reg_rd,
    input  logic                          reg_wr,
    input  logic [11:0]                   reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic                          reg_ready,
    output logic                          reg_rvalid,
    output logic [31:0]                   reg_rdata,
    output logic [3:0]                    irq,
    output logic                          inj_valid,
    output logic                          inj_target,
    output logic [7:0]                    inj_bit
);

    logic [NUM_CLASSES-1:0][ADDR_W-1:0] cls_addr;
    logic [NUM_CLASSES-1:0][CNT_W-1:0]  cls_count;
    logic [NUM_CLASSES-1:0]             rd_clr;
    logic                               inj_wr;

    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_class
        ecc_class_rec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rec (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_strobe[k]),
            .ev_addr  (ev_addr[k*ADDR_W +: ADDR_W]),
            .rd_clr   (rd_clr[k]),
            .cap_addr (cls_addr[k]),
            .count    (cls_count[k]),
            .irq      (irq[k])
        );
    end

    ecc_reg_port #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BANKS(BANKS), .WAYS(WAYS),
        .LG_SETS(LG_SETS), .LG_BLOCK(LG_BLOCK)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .cls_addr   (cls_addr),
        .cls_count  (cls_count),
        .reg_ready  (reg_ready),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata),
        .rd_clr     (rd_clr),
        .inj_wr     (inj_wr)
    );

    ecc_inject_gate u_inject (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (inj_wr),
        .wdata      (reg_wdata),
        .inj_valid  (inj_valid),
        .inj_target (inj_target),
        .inj_bit    (inj_bit)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> ((irq == 4'b0) && reg_ready && !reg_rvalid && !inj_valid));

endmodule

// File: tb/ecc_report_unit_test.sv
`timescale 1ns/1ps
module ecc_report_unit_test;

    localparam int AW = 64;
    localparam int CW = 4;
    localparam int CMAX = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   ev_strobe = '0;
    logic [255:0] ev_addr = '0;
    logic         reg_rd = 1'b0, reg_wr = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic         reg_ready, reg_rvalid, inj_valid, inj_target;
    logic [31:0]  reg_rdata;
    logic [3:0]   irq;
    logic [7:0]   inj_bit;

    always #2.5 clk = ~clk;

    ecc_report_unit #(.ADDR_W(AW), .CNT_W(CW), .BANKS(2), .WAYS(8),
                      .LG_SETS(10), .LG_BLOCK(6)) uut (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_addr(ev_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ready(reg_ready), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .irq(irq), .inj_valid(inj_valid), .inj_target(inj_target), .inj_bit(inj_bit));

    int n_chk = 0, n_fail = 0;
    logic [63:0] m_addr [4];
    int          m_cnt  [4];
    bit          m_irq  [4];
    logic [7:0]  m_way = 8'd7;

    function automatic logic [11:0] cbase(input int k);
        if (k == 0) return 12'h100;
        if (k == 1) return 12'h140;
        if (k == 2) return 12'h160;
        return 12'h120;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == 12'h000) return 32'h060A_0802;
        if (a == 12'h008) return {24'd0, m_way};
        for (int k = 0; k < 4; k++) begin
            if (a == cbase(k))         return m_addr[k][31:0];
            if (a == cbase(k) + 12'h4) return m_addr[k][63:32];
            if (a == cbase(k) + 12'h8) return 32'(m_cnt[k]);
        end
        return 32'd0;
    endfunction

    function automatic logic [3:0] exp_irq();
        return {m_irq[3], m_irq[2], m_irq[1], m_irq[0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One cycle of events and an optional read; checks read data.
    task automatic step(input logic [3:0] evm, input logic [255:0] addrs,
                        input bit rd, input logic [11:0] ra, input string tag);
        logic [31:0] expv;
        @(negedge clk);
        ev_strobe = evm; ev_addr = addrs; reg_rd = rd; reg_addr = ra;
        expv = exp_read(ra);
        @(posedge clk); #1;
        ev_strobe = '0; reg_rd = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (rd && ra == cbase(k) + 12'h8) m_irq[k] = 1'b0;
            if (evm[k]) begin
                m_addr[k] = addrs[k*64 +: 64];
                if (m_cnt[k] < CMAX) m_cnt[k]++;
                m_irq[k] = 1'b1;
            end
        end
        if (rd) begin
            @(negedge clk);
            chk(reg_rvalid && !reg_ready, {tag, " R11 handshake"},
                {reg_rvalid, reg_ready}, 2'b10);
            chk(reg_rdata == expv, tag, reg_rdata, expv);
            @(posedge clk); #1;
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(4'b0, '0, 1'b1, a, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == 12'h008) m_way = d[7:0];
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk);
        chk(irq == exp_irq(), tag, irq, exp_irq());
    endtask

    task automatic inj(input logic [31:0] d, input bit ok);
        wr(12'h040, d);
        @(negedge clk);
        chk(inj_valid == ok, ok ? "R7 pulse" : "R8 rejected", inj_valid, ok);
        if (ok) begin
            chk({inj_target, inj_bit} == {d[16], d[7:0]}, "R7 fields",
                {inj_target, inj_bit}, {d[16], d[7:0]});
            @(negedge clk);
            chk(!inj_valid, "R7 single cycle", inj_valid, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] a;
        void'($urandom(32'd4242));
        for (int k = 0; k < 4; k++) begin m_addr[k] = '0; m_cnt[k] = 0; m_irq[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(irq == 4'b0 && reg_ready && !reg_rvalid && !inj_valid, "R1 reset outputs",
            {irq, reg_ready, reg_rvalid, inj_valid}, 7'b0000100);
        rd(12'h108, "R1 count at reset");
        rd(12'h164, "R1 addr at reset");

        // R9, R10, R12
        rd(12'h000, "R9 geometry");
        rd(12'h008, "R10 way reset");
        wr(12'h008, 32'hABCD_1203);
        rd(12'h008, "R10 way write");
        rd(12'h200, "R12 unmapped");
        rd(12'h10C, "R12 unmapped gap");

        // R2 capture and R4 ordering
        a = '0; a[63:0] = 64'h1234_5678_9ABC_DEF0;
        step(4'b0001, a, 1'b0, 12'h0, "R2 event");
        check_irq("R4 dir-corr bit0");
        rd(12'h100, "R2 addr low");
        rd(12'h104, "R2 addr high");
        a = '0; a[2*64 +: 64] = 64'hFEED_0000_0000_0040;
        step(4'b0100, a, 1'b0, 12'h0, "R4 event");
        check_irq("R4 data-uncorr bit2");
        rd(12'h160, "R2 data-uncorr low");
        rd(12'h164, "R2 data-uncorr high");
        check_irq("R5 addr read keeps irq");
        rd(12'h168, "R5 count read");
        check_irq("R5 clear after count read");
        rd(12'h108, "R3 count one");

        // R3 saturation
        for (int i = 0; i < 20; i++) begin
            a = '0; a[3*64 +: 64] = 64'(i);
            step(4'b1000, a, 1'b0, 12'h0, "R3 burst");
        end
        rd(12'h128, "R3 saturated count");
        rd(12'h120, "R2 latest address");
        check_irq("R5 count read on dir-uncorr");

        // R6 collision
        a = '0; a[64 +: 64] = 64'h77;
        step(4'b0010, a, 1'b0, 12'h0, "R6 prep");
        step(4'b0010, a, 1'b1, 12'h148, "R6 read returns old count");
        check_irq("R6 irq kept");
        rd(12'h148, "R6 count after collision");
        check_irq("R6 cleared later");

        // R7 / R8 injection
        inj(32'h0000_00FE, 1'b1);
        inj(32'h0000_00FF, 1'b0);
        inj(32'h0001_0000, 1'b1);
        inj(32'h0001_00FE, 1'b1);
        inj(32'h0001_00FF, 1'b0);
        inj(32'h0000_FFFF, 1'b0);
        inj(32'h0002_0001, 1'b0);

        // random mix: R2 R3 R4 R5 R6
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  evm;
            logic [11:0] ra;
            bit          dord;
            int          k;
            evm = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0;
            for (int w = 0; w < 8; w++) a[w*32 +: 32] = $urandom;
            dord = ($urandom % 2) == 0;
            k = int'($urandom % 4);
            ra = cbase(k) + 12'(4 * ($urandom % 3));
            step(evm, a, dord, ra, "R2 R3 R6 random read");
            check_irq("R4 R5 random irq");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule